// File: doc/BRIEF.md
# Strap-Pin Bus Address Resolver

This block works out a device's bus address from a chain of up to seven strap pins. It reads them once, when reset is released. Each pin comes in as two digital signals: the level the pin is pulled to, and a flag that is high when the pull is strong and low when it is weak. A separate front end measures the pull strength; this block does not.

The block walks the pins from pin 0 upward, and each pin it visits gives one address bit. A weak pull means the chain goes on to the next pin. The first strong pull ends the chain. The levels of the visited pins form the low address bits. Every address bit above the chain takes its value from a parameter. Every pin outside the chain is marked as free for general-purpose I/O.

The results are captured on the first clock after reset is released and are then held until the next reset. If pins 0 to 5 are all weak, pin 6 ends the chain whatever its pull. If pin 6 is also weak, a fault flag records that the strapping was illegal.

Top module: `strap_addr_resolver`

## Requirements
- R1: While reset is applied and on the cycle after it, `strap_done` and `strap_fault` are 0, `addr_width` is 0, `gpio_release` is all zeros and `dev_addr` equals the `DEFAULT_ADDR` parameter (default 7'h20).
- R2: The pins are sampled on the first rising clock edge at which reset is low. `strap_done` is 1 from that edge onward and stays 1 until reset is asserted again.
- R3: After sampling, `dev_addr[0]` equals the level that `pad_level[0]` had when it was sampled, whatever the pull strength of pin 0.
- R4: After sampling, `addr_width` is one more than the index of the lowest pin whose `pad_strong` bit is 1, looking only at pins 0 to 5. A value of 1 means pin 0 alone.
- R5: For every bit index i below `addr_width`, `dev_addr[i]` equals the sampled `pad_level[i]`. For every index at or above `addr_width`, it equals bit i of `DEFAULT_ADDR`.
- R6: Bit i of `gpio_release` is 1 (pin free for general-purpose I/O) exactly when i is at or above `addr_width`.
- R7: When `pad_strong[5:0]` is all zeros, `addr_width` is 7 and pin 6 supplies `dev_addr[6]`, whatever the value of `pad_strong[6]`.
- R8: `strap_fault` is 1 after sampling exactly when all seven `pad_strong` bits were 0. Once set, it stays set until reset.
- R9: After sampling, changes on `pad_level` and `pad_strong` have no effect on any output until the next reset.
- R10: A new reset clears all results, and the next release of reset samples the pins again from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_level | input | 7 | Level each strap pin is pulled to |
| pad_strong | input | 7 | 1 = strong pull, 0 = weak pull, per pin |
| dev_addr | output | 7 | Resolved device bus address |
| addr_width | output | 3 | Number of pins used as address bits (0 before sampling) |
| gpio_release | output | 7 | 1 = pin not used for addressing, free for I/O |
| strap_fault | output | 1 | Sticky flag: illegal strapping (all seven pins weak) |
| strap_done | output | 1 | Results captured and valid |

## Verification
The assertions check the following on every cycle:
- the cleared state that follows reset;
- that `strap_done` is set one cycle after release and then stays set;
- that captured results stay frozen while pins change;
- that the width stays in range;
- that the release mask is consistent with the width;
- that address bit 0 follows pin 0.

Some behaviour can only be shown by the bench's sweep. The sweep covers all 16384 combinations of level and strength. It checks, for each one, that the chain stops at the correct pin and that each address bit comes from a pin or from the default as it should. It also checks the case where pin 6 ends the chain by itself and the exact set of strappings that raise the fault flag.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int unsigned STRAP_PINS = 7;
    localparam int unsigned ADDR_W     = 7;
    localparam int unsigned CNT_W      = $clog2(STRAP_PINS + 1);

    typedef logic [STRAP_PINS-1:0] pin_vec_t;
    typedef logic [ADDR_W-1:0]     addr_t;
    typedef logic [CNT_W-1:0]      cnt_t;

    typedef struct packed {
        addr_t    addr;
        cnt_t     width;
        pin_vec_t gpio_free;
        logic     bad_strap;
    } strap_result_t;

    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_LOCKED = 1'b1
    } strap_phase_t;

    function automatic cnt_t count_used(input pin_vec_t used);
        cnt_t n;
        n = '0;
        for (int i = 0; i < STRAP_PINS; i++) begin
            n = n + cnt_t'(used[i]);
        end
        return n;
    endfunction

    function automatic strap_result_t cleared_result(input addr_t dflt);
        strap_result_t r;
        r.addr      = dflt;
        r.width     = '0;
        r.gpio_free = '0;
        r.bad_strap = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/strap_chain_scan.sv
module strap_chain_scan
    import strap_pkg::*;
(
    input  pin_vec_t pin_strong,
    output pin_vec_t pin_used,
    output logic     chain_overrun
);

    // open_q[i] is 1 when every pin below i is weakly pulled
    pin_vec_t open_q;

    assign open_q[0] = 1'b1;

    for (genvar g = 1; g < STRAP_PINS; g++) begin : g_chain
        assign open_q[g] = open_q[g-1] & ~pin_strong[g-1];
    end

    // The last pin ends the chain whatever its pull strength
    assign pin_used      = open_q;
    assign chain_overrun = open_q[STRAP_PINS-1] & ~pin_strong[STRAP_PINS-1];

endmodule

// File: rtl/strap_addr_merge.sv
module strap_addr_merge
    import strap_pkg::*;
#(
    parameter addr_t DEFAULT_ADDR = 7'h20
) (
    input  pin_vec_t      pin_level,
    input  pin_vec_t      pin_used,
    input  logic          chain_overrun,
    output strap_result_t merged
);

    addr_t addr_mix;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < STRAP_PINS) begin : g_pin
            assign addr_mix[i] = pin_used[i] ? pin_level[i] : DEFAULT_ADDR[i];
        end else begin : g_fixed
            assign addr_mix[i] = DEFAULT_ADDR[i];
        end
    end

    always_comb begin
        merged.addr      = addr_mix;
        merged.width     = count_used(pin_used);
        merged.gpio_free = ~pin_used;
        merged.bad_strap = chain_overrun;
    end

endmodule

// File: rtl/strap_result_reg.sv
module strap_result_reg
    import strap_pkg::*;
#(
    parameter addr_t DEFAULT_ADDR = 7'h20
) (
    input  logic          clk,
    input  logic          rst,
    input  strap_result_t next_res,
    input  pin_vec_t      level_in,
    output strap_result_t held_res,
    output logic          locked
);

    strap_phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_SAMPLE;
            held_res <= cleared_result(DEFAULT_ADDR);
        end else if (phase_q == PH_SAMPLE) begin
            phase_q  <= PH_LOCKED;
            held_res <= next_res;
        end
    end

    assign locked = (phase_q == PH_LOCKED);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!locked && held_res.width == '0 && held_res.gpio_free == '0
                 && !held_res.bad_strap && held_res.addr == DEFAULT_ADDR)); // R1

    AST_LOCK_NEXT: assert property (@(posedge clk) disable iff (rst)
        !locked |=> locked); // R2

    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R2

    AST_BIT0_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> held_res.addr[0] == $past(level_in[0])); // R3

    AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (rst)
        locked |-> (held_res.width >= cnt_t'(1) && held_res.width <= cnt_t'(STRAP_PINS))); // R4

    AST_FREE_MATCHES: assert property (@(posedge clk) disable iff (rst)
        locked |-> ($countones(held_res.gpio_free) == STRAP_PINS - int'(held_res.width))); // R6

    AST_FAULT_FULL: assert property (@(posedge clk) disable iff (rst)
        (locked && held_res.bad_strap) |-> held_res.width == cnt_t'(STRAP_PINS)); // R8

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(held_res)); // R9

endmodule

// File: rtl/strap_addr_resolver.sv
module strap_addr_resolver
    import strap_pkg::*;
#(
    parameter addr_t DEFAULT_ADDR = 7'h20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [STRAP_PINS-1:0] pad_level,
    input  logic [STRAP_PINS-1:0] pad_strong,
    output logic [ADDR_W-1:0]     dev_addr,
    output logic [CNT_W-1:0]      addr_width,
    output logic [STRAP_PINS-1:0] gpio_release,
    output logic                  strap_fault,
    output logic                  strap_done
);

    pin_vec_t      used_w;
    logic          overrun_w;
    strap_result_t merged_w;
    strap_result_t held_w;

    strap_chain_scan u_scan (
        .pin_strong    (pad_strong),
        .pin_used      (used_w),
        .chain_overrun (overrun_w)
    );

    strap_addr_merge #(.DEFAULT_ADDR(DEFAULT_ADDR)) u_merge (
        .pin_level     (pad_level),
        .pin_used      (used_w),
        .chain_overrun (overrun_w),
        .merged        (merged_w)
    );

    strap_result_reg #(.DEFAULT_ADDR(DEFAULT_ADDR)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .next_res (merged_w),
        .level_in (pad_level),
        .held_res (held_w),
        .locked   (strap_done)
    );

    assign dev_addr     = held_w.addr;
    assign addr_width   = held_w.width;
    assign gpio_release = held_w.gpio_free;
    assign strap_fault  = held_w.bad_strap;

endmodule

// File: tb/strap_addr_resolver_tb_top.sv
`timescale 1ns/1ps
module strap_addr_resolver_tb_top;

    localparam logic [6:0] DEF = 7'h20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] pad_level  = '0;
    logic [6:0] pad_strong = '0;
    logic [6:0] dev_addr;
    logic [2:0] addr_width;
    logic [6:0] gpio_release;
    logic       strap_fault;
    logic       strap_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    strap_addr_resolver #(.DEFAULT_ADDR(DEF)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .pad_level    (pad_level),
        .pad_strong   (pad_strong),
        .dev_addr     (dev_addr),
        .addr_width   (addr_width),
        .gpio_release (gpio_release),
        .strap_fault  (strap_fault),
        .strap_done   (strap_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [6:0] lv, input logic [6:0] st);
        int         n;
        logic [6:0] ea;
        logic [6:0] ef;
        logic       ee;
        logic [6:0] snap_a;
        logic [6:0] snap_f;
        logic [2:0] snap_w;
        logic       snap_e;
        // expected values from the requirements
        n = 7;
        for (int i = 0; i < 6; i++) begin
            if (st[i]) begin
                n = i + 1;
                break;
            end
        end
        ee = (st == 7'd0);
        for (int i = 0; i < 7; i++) begin
            ea[i] = (i < n) ? lv[i] : DEF[i];
            ef[i] = (i >= n);
        end

        @(negedge clk);
        rst        = 1'b1;
        pad_level  = lv;
        pad_strong = st;
        @(negedge clk);
        // R1 / R10: cleared state after reset
        chk("R1", "reset state",
            int'({strap_done, strap_fault, addr_width, gpio_release, dev_addr}),
            int'({1'b0, 1'b0, 3'd0, 7'd0, DEF}));
        chk("R10", "done cleared on re-reset", int'(strap_done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", "done after first edge", int'(strap_done), 1);
        chk("R3", "addr bit0", int'(dev_addr[0]), int'(lv[0]));
        chk(st[5:0] == 6'd0 ? "R7" : "R4", "width", int'(addr_width), n);
        chk("R5", "address", int'(dev_addr), int'(ea));
        chk("R6", "gpio release", int'(gpio_release), int'(ef));
        chk("R8", "fault", int'(strap_fault), int'(ee));
        snap_a = dev_addr;
        snap_f = gpio_release;
        snap_w = addr_width;
        snap_e = strap_fault;
        pad_level  = ~lv;
        pad_strong = ~st;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "hold after pin change",
            int'({strap_done, snap_e, snap_w, snap_f, snap_a}),
            int'({1'b1, strap_fault, addr_width, gpio_release, dev_addr}));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1", "done low in reset", int'(strap_done), 0);
        for (int c = 0; c < 16384; c++) begin
            run_case(c[6:0], c[13:7]);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule